// File: doc/BRIEF.md
# Single-Issue Instruction Stage Sequencer

This block steers a small 32-bit core that works on exactly one instruction at a time. A single state register walks the core through the following stages:

- Fetch
- Decode
- Execute
- An optional Memory stage
- Writeback

One enable output per stage is driven high, and at most one of them is high in any cycle. Fetch and Memory wait on completion strobes from the memory side. Decode and Writeback always last a single cycle.

Execute normally lasts one cycle. While the core is in decode, the sequencer samples two hints from the decoder: a long-operation hint and a load/store hint. When the long-operation hint was taken, execute is held for as long as the arithmetic unit raises its busy flag. Multiply and divide use this path, and ordinary instructions never lose a cycle to it. The load/store hint selects whether execute is followed by Memory or goes straight to Writeback.

A pending interrupt request is acted on only at the instruction boundary. If one is pending during writeback, the sequencer enters a one-cycle interrupt-entry stage instead of returning to fetch.

States and transitions:

- `ST_FETCH` goes to `ST_DECODE` on `fetch_done`.
- `ST_DECODE` goes to `ST_EXEC` unconditionally.
- `ST_EXEC` stays in place while the long hint is latched and `alu_busy` is high. Otherwise it goes to `ST_MEM` if the load/store hint is latched, or to `ST_WB` if not.
- `ST_MEM` goes to `ST_WB` on `mem_done`.
- `ST_WB` goes to `ST_IRQ` if `irq_pending` is high, or to `ST_FETCH` if not.
- `ST_IRQ` goes to `ST_FETCH` unconditionally.

Top module: `cpu_stage_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves only `en_fetch` high and every other enable low.
- R2: In every cycle outside reset, exactly one of the six enables is high.
- R3: Fetch stays active while `fetch_done` is low. The edge at which `fetch_done` is high moves the sequencer to decode.
- R4: Decode lasts exactly one cycle and is always followed by execute.
- R5: If `dec_long` was low in the decode cycle, execute lasts exactly one cycle whatever the value of `alu_busy`.
- R6: If `dec_long` was high in the decode cycle, execute stays active at every edge where `alu_busy` is high. It leaves at the first edge where `alu_busy` is low.
- R7: Both hints are sampled only in the decode cycle. Changes to `dec_long` or `dec_ldst` during execute have no effect on the current instruction.
- R8: If `dec_ldst` was high in the decode cycle, execute is followed by memory. Memory stays active while `mem_done` is low and moves to writeback at the edge where `mem_done` is high.
- R9: If `dec_ldst` was low in the decode cycle, execute is followed directly by writeback.
- R10: Writeback lasts exactly one cycle. With `irq_pending` low, it is followed by fetch.
- R11: With `irq_pending` high during writeback, the next stage is interrupt entry, which lasts one cycle and is followed by fetch.
- R12: `irq_pending` has no effect in any stage other than writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_done | input | 1 | Instruction fetch completed |
| mem_done | input | 1 | Data access completed |
| dec_long | input | 1 | Decoder hint: execute may take several cycles |
| dec_ldst | input | 1 | Decoder hint: instruction needs the memory stage |
| alu_busy | input | 1 | Arithmetic unit still working |
| irq_pending | input | 1 | Interrupt request waiting |
| en_fetch | output | 1 | Fetch stage enable |
| en_decode | output | 1 | Decode stage enable |
| en_exec | output | 1 | Execute stage enable |
| en_mem | output | 1 | Memory stage enable |
| en_wb | output | 1 | Writeback stage enable |
| en_irq | output | 1 | Interrupt entry enable |

## Verification
The assertions check every local transition rule on every cycle:

- exactly one enable is high;
- fetch and memory hold until their strobes arrive;
- decode is always followed by execute;
- execute never holds once `alu_busy` is low;
- writeback branches on `irq_pending`;
- interrupt entry lasts one cycle.

Some behaviour depends on what the decoder reported cycles earlier, and only the directed scenarios can show it:

- the hints being latched at decode (R7);
- `alu_busy` being ignored for short instructions (R5);
- the choice between memory and writeback (R8, R9);
- interrupts being ignored mid-instruction (R12).

The scenarios also cover the reset state.

// File: rtl/cpu_stage_seq_pkg.sv
package cpu_stage_seq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_MEM    = 3'd3,
        ST_WB     = 3'd4,
        ST_IRQ    = 3'd5
    } stage_t;

    localparam int STAGE_COUNT = 6;

    typedef struct packed {
        logic long_op;
        logic ldst_op;
    } hint_t;

endpackage

// File: rtl/cpu_stage_hint_latch.sv
module cpu_stage_hint_latch
    import cpu_stage_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  capture,
    input  hint_t hint_in,
    output hint_t hint_q
);

    // Hints are only valid from the decoder during the decode cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            hint_q <= '0;
        end else if (capture) begin
            hint_q <= hint_in;
        end
    end

endmodule

// File: rtl/cpu_stage_next.sv
module cpu_stage_next
    import cpu_stage_seq_pkg::*;
(
    input  stage_t cur,
    input  hint_t  hint_q,
    input  logic   fetch_done,
    input  logic   mem_done,
    input  logic   alu_busy,
    input  logic   irq_pending,
    output stage_t nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_FETCH:  nxt = fetch_done ? ST_DECODE : ST_FETCH;
            ST_DECODE: nxt = ST_EXEC;
            ST_EXEC: begin
                if (hint_q.long_op && alu_busy) begin
                    nxt = ST_EXEC;
                end else if (hint_q.ldst_op) begin
                    nxt = ST_MEM;
                end else begin
                    nxt = ST_WB;
                end
            end
            ST_MEM:    nxt = mem_done ? ST_WB : ST_MEM;
            ST_WB:     nxt = irq_pending ? ST_IRQ : ST_FETCH;
            ST_IRQ:    nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/cpu_stage_enables.sv
module cpu_stage_enables
    import cpu_stage_seq_pkg::*;
(
    input  stage_t                  cur,
    output logic [STAGE_COUNT-1:0]  en_vec
);

    // One bit per stage, indexed by the state encoding.
    for (genvar g = 0; g < STAGE_COUNT; g++) begin : g_en
        assign en_vec[g] = (cur == stage_t'(g));
    end

endmodule

// File: rtl/cpu_stage_seq.sv
module cpu_stage_seq
    import cpu_stage_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_done,
    input  logic mem_done,
    input  logic dec_long,
    input  logic dec_ldst,
    input  logic alu_busy,
    input  logic irq_pending,
    output logic en_fetch,
    output logic en_decode,
    output logic en_exec,
    output logic en_mem,
    output logic en_wb,
    output logic en_irq
);

    stage_t                 stage_q;
    stage_t                 stage_d;
    hint_t                  hint_q;
    hint_t                  hint_in;
    logic [STAGE_COUNT-1:0] en_vec;

    assign hint_in = '{long_op: dec_long, ldst_op: dec_ldst};

    cpu_stage_hint_latch u_hint (
        .clk     (clk),
        .rst     (rst),
        .capture (stage_q == ST_DECODE),
        .hint_in (hint_in),
        .hint_q  (hint_q)
    );

    cpu_stage_next u_next (
        .cur         (stage_q),
        .hint_q      (hint_q),
        .fetch_done  (fetch_done),
        .mem_done    (mem_done),
        .alu_busy    (alu_busy),
        .irq_pending (irq_pending),
        .nxt         (stage_d)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_FETCH;
        end else begin
            stage_q <= stage_d;
        end
    end

    cpu_stage_enables u_en (
        .cur    (stage_q),
        .en_vec (en_vec)
    );

    // Output mapping.
    always_comb begin
        en_fetch  = en_vec[ST_FETCH];
        en_decode = en_vec[ST_DECODE];
        en_exec   = en_vec[ST_EXEC];
        en_mem    = en_vec[ST_MEM];
        en_wb     = en_vec[ST_WB];
        en_irq    = en_vec[ST_IRQ];
    end

endmodule

// File: rtl/cpu_stage_seq_chk.sv
module cpu_stage_seq_chk (
    input logic clk,
    input logic rst,
    input logic fetch_done,
    input logic mem_done,
    input logic alu_busy,
    input logic irq_pending,
    input logic en_fetch,
    input logic en_decode,
    input logic en_exec,
    input logic en_mem,
    input logic en_wb,
    input logic en_irq
);

    logic [5:0] en_all;
    assign en_all = {en_irq, en_wb, en_mem, en_exec, en_decode, en_fetch};

    // R2
    one_stage_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(en_all) == 1);

    // R3
    fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_fetch && !fetch_done) |=> en_fetch);

    // R3
    fetch_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (en_fetch && fetch_done) |=> en_decode);

    // R4
    decode_once_chk: assert property (@(posedge clk) disable iff (rst)
        en_decode |=> en_exec);

    // R6
    exec_release_chk: assert property (@(posedge clk) disable iff (rst)
        (en_exec && !alu_busy) |=> (en_mem || en_wb));

    // R8
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en_mem && !mem_done) |=> en_mem);

    // R8
    mem_leave_chk: assert property (@(posedge clk) disable iff (rst)
        (en_mem && mem_done) |=> en_wb);

    // R10
    wb_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wb && !irq_pending) |=> en_fetch);

    // R11
    wb_to_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (en_wb && irq_pending) |=> en_irq);

    // R11
    irq_once_chk: assert property (@(posedge clk) disable iff (rst)
        en_irq |=> en_fetch);

endmodule

bind cpu_stage_seq cpu_stage_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_done  (fetch_done),
    .mem_done    (mem_done),
    .alu_busy    (alu_busy),
    .irq_pending (irq_pending),
    .en_fetch    (en_fetch),
    .en_decode   (en_decode),
    .en_exec     (en_exec),
    .en_mem      (en_mem),
    .en_wb       (en_wb),
    .en_irq      (en_irq)
);

// File: tb/cpu_stage_seq_tb.sv
`timescale 1ns/1ps
module cpu_stage_seq_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_done = 1'b0;
    logic mem_done = 1'b0;
    logic dec_long = 1'b0;
    logic dec_ldst = 1'b0;
    logic alu_busy = 1'b0;
    logic irq_pending = 1'b0;
    logic en_fetch, en_decode, en_exec, en_mem, en_wb, en_irq;

    int n_checks = 0;
    int n_fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Bit order: {irq, wb, mem, exec, decode, fetch}
    localparam logic [5:0] S_F = 6'b000001;
    localparam logic [5:0] S_D = 6'b000010;
    localparam logic [5:0] S_E = 6'b000100;
    localparam logic [5:0] S_M = 6'b001000;
    localparam logic [5:0] S_W = 6'b010000;
    localparam logic [5:0] S_I = 6'b100000;

    always #2 clk = ~clk;

    cpu_stage_seq u_dut (
        .clk(clk), .rst(rst), .fetch_done(fetch_done), .mem_done(mem_done),
        .dec_long(dec_long), .dec_ldst(dec_ldst), .alu_busy(alu_busy),
        .irq_pending(irq_pending), .en_fetch(en_fetch), .en_decode(en_decode),
        .en_exec(en_exec), .en_mem(en_mem), .en_wb(en_wb), .en_irq(en_irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            n_fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [5:0] exp, input string req);
        logic [5:0] act;
        act = {en_irq, en_wb, en_mem, en_exec, en_decode, en_fetch};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: act=%b exp=%b at t=%0t", req, act, exp, $time);
        end
    endtask

    // From fetch: strobe fetch_done, land in decode with given hints driven.
    task automatic enter_decode(input logic lng, input logic ldst);
        fetch_done = 1'b1;
        step();
        fetch_done = 1'b0;
        expect_st(S_D, "R3 fetch->decode");
        dec_long = lng;
        dec_ldst = ldst;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        fetch_done = 1'b1;
        step();
        step();
        expect_st(S_F, "R1 reset state");
        rst = 1'b0;
        fetch_done = 1'b0;
    endtask

    task automatic t_short_plain();
        for (int i = 0; i < 3; i++) begin
            irq_pending = 1'b1; // R12: no effect in fetch
            step();
            expect_st(S_F, "R3 fetch hold / R12");
        end
        irq_pending = 1'b0;
        enter_decode(1'b0, 1'b0);
        step();
        expect_st(S_E, "R4 decode->exec");
        alu_busy = 1'b1; // R5: ignored
        step();
        expect_st(S_W, "R5 R9 short exec to wb");
        alu_busy = 1'b0;
        step();
        expect_st(S_F, "R10 wb->fetch");
    endtask

    task automatic t_long_op();
        enter_decode(1'b1, 1'b0);
        step();
        expect_st(S_E, "R4 decode->exec");
        dec_long = 1'b0; // R7: latched value keeps holding
        alu_busy = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            expect_st(S_E, "R6 R7 exec held while busy");
        end
        alu_busy = 1'b0;
        step();
        expect_st(S_W, "R6 release to wb");
        step();
        expect_st(S_F, "R10 wb->fetch");
    endtask

    task automatic t_late_hint();
        enter_decode(1'b0, 1'b0);
        step();
        expect_st(S_E, "R4 decode->exec");
        dec_long = 1'b1;
        dec_ldst = 1'b1;
        alu_busy = 1'b1;
        step();
        expect_st(S_W, "R7 late hints ignored");
        dec_long = 1'b0;
        dec_ldst = 1'b0;
        alu_busy = 1'b0;
        step();
        expect_st(S_F, "R10 wb->fetch");
    endtask

    task automatic t_mem_irq();
        enter_decode(1'b0, 1'b1);
        step();
        expect_st(S_E, "R4 decode->exec");
        dec_ldst = 1'b0;
        step();
        expect_st(S_M, "R8 exec->mem");
        irq_pending = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step();
            expect_st(S_M, "R8 R12 mem hold");
        end
        mem_done = 1'b1;
        step();
        expect_st(S_W, "R8 mem->wb");
        mem_done = 1'b0;
        step();
        expect_st(S_I, "R11 wb->irq");
        irq_pending = 1'b0;
        step();
        expect_st(S_F, "R11 irq->fetch");
    endtask

    task automatic t_long_mem();
        enter_decode(1'b1, 1'b1);
        step();
        expect_st(S_E, "R4 decode->exec");
        alu_busy = 1'b1;
        step();
        expect_st(S_E, "R6 exec held");
        alu_busy = 1'b0;
        mem_done = 1'b1;
        step();
        expect_st(S_M, "R6 R8 exec->mem");
        step();
        expect_st(S_W, "R8 mem->wb");
        mem_done = 1'b0;
        irq_pending = 1'b1;
        step();
        expect_st(S_I, "R11 wb->irq");
        step();
        expect_st(S_F, "R11 irq single cycle");
        irq_pending = 1'b0;
    endtask

    initial begin
        t_reset();
        t_short_plain();
        t_long_op();
        t_late_hint();
        t_mem_irq();
        t_long_mem();
        t_reset();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule